// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory. When a burst starts, it captures a full address. The low two bits become the starting beat. The upper bits are held for the whole burst. On each later cycle with the step input high, the low bits move to the next beat of the burst.

Two beat orders are available, and a select input picks one. In linear order the beats count upward modulo four from the start. In interleaved order each beat is the start XOR the beat index. The sequence wraps after the fourth beat and does not stop.

Both outputs come straight from registers. A change on the inputs at one rising edge appears on the outputs right after that edge. Producing the start strobe, the storage array and the data path belong to other blocks.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs become zero after that edge. This holds whatever the other inputs are.
- R2: When `load` is high at an edge, the edge captures `addr_in`. After it, `burst_lo` equals `addr_in[1:0]` and `burst_addr` equals the whole captured `addr_in`.
- R3: When `load` and `advance` are both low at an edge and `order_sel` does not change, both outputs keep their values. This holds whatever `addr_in` is.
- R4: With `order_sel` = 0 (linear), after n advances since the load, `burst_lo` = (start + n) mod 4. For a start of 1 this gives 1, 2, 3, 0.
- R5: With `order_sel` = 1 (interleaved), after n advances since the load, `burst_lo` = start XOR (n mod 4). For a start of 1 this gives 1, 0, 3, 2.
- R6: Advances past the fourth beat wrap to the beginning of the same sequence. After four more advances, `burst_lo` again equals the start.
- R7: When `load` and `advance` are both high at the same edge, the load wins. The output shows the new start, and the advance does not step it.
- R8: `burst_addr[ADDR_W-1:2]` changes only at an edge with `load` high. Between loads it keeps the captured upper bits, whatever `addr_in` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start a burst from `addr_in` |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | Starting address of a burst |
| burst_lo | output | 2 | Current beat address (low bits) |
| burst_addr | output | ADDR_W | Held upper bits joined with the current beat address |

## Verification
The bench builds the block with `ADDR_W` = 6 and the two-bit beat field. This leaves four upper bits, so every upper value can be combined with every start beat in both orders. For each such load it steps six beats, which crosses the wrap. Between the steps it holds with noise on `addr_in`. It also drives load and step together, to show which one takes priority.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2,
  localparam int UPPER_W = ADDR_W - BEAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic [BEAT_W-1:0]  start_nxt,
  output logic [UPPER_W-1:0] upper_nxt,
  output logic [UPPER_W-1:0] upper_q
);
  logic [BEAT_W-1:0] start_q;

  always_comb begin
    start_nxt = start_q;
    upper_nxt = upper_q;
    if (load) begin
      start_nxt = addr_in[BEAT_W-1:0];
      upper_nxt = addr_in[ADDR_W-1:BEAT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      upper_q <= '0;
    end else begin
      start_q <= start_nxt;
      upper_q <= upper_nxt;
    end
  end

  // R8: held upper bits move only on a load
  assert_upper_held_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(upper_q));
endmodule

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  output logic [BEAT_W-1:0] step_nxt,
  output logic [BEAT_W-1:0] step_q
);
  always_comb begin
    if (load)         step_nxt = '0;
    else if (advance) step_nxt = step_q + 1'b1;
    else              step_nxt = step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_nxt;
  end

  // R6: the beat index wraps instead of saturating
  assert_step_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && advance && (&step_q)) |=> (step_q == '0));
  // R7: a load clears the index even with advance high
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (step_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] step,
  output logic [BEAT_W-1:0] beat_addr
);
  import burst_pkg::*;

  logic [BEAT_W-1:0] lin_addr;
  logic [BEAT_W-1:0] ilv_addr;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_addr[b] = start[b] ^ step[b];
    end
  endgenerate

  assign lin_addr = start + step;

  always_comb begin
    if (order_e'(order_sel) == ORDER_INTERLEAVE) beat_addr = ilv_addr;
    else                                         beat_addr = lin_addr;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2,
  localparam int UPPER_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [BEAT_W-1:0] burst_lo,
  output logic [ADDR_W-1:0] burst_addr
);
  logic [BEAT_W-1:0]  start_nxt;
  logic [UPPER_W-1:0] upper_nxt;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  step_nxt;
  logic [BEAT_W-1:0]  step_q;
  logic [BEAT_W-1:0]  beat_nxt;

  burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in),
    .start_nxt(start_nxt), .upper_nxt(upper_nxt), .upper_q(upper_q));

  burst_step_ctr #(.BEAT_W(BEAT_W)) u_step (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .step_nxt(step_nxt), .step_q(step_q));

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_sel(order_sel), .start(start_nxt), .step(step_nxt),
    .beat_addr(beat_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_lo   <= '0;
      burst_addr <= '0;
    end else begin
      burst_lo   <= beat_nxt;
      burst_addr <= {upper_nxt, beat_nxt};
    end
  end

  // R2: a load shows the captured address on the next cycle
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (burst_addr == $past(addr_in)));
  // R3: idle cycles with a steady order select leave the outputs alone
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance && $stable(order_sel)) |=> $stable(burst_addr));
  // R4: linear steps add one modulo the beat count
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && advance && !order_sel && $stable(order_sel))
      |=> (burst_lo == BEAT_W'($past(burst_lo) + 1'b1)));
  // R5: interleaved step from an even index flips only bit 0
  assert_ilv_even_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && advance && order_sel && $stable(order_sel) && !step_q[0])
      |=> (burst_lo == ($past(burst_lo) ^ BEAT_W'(1))));
endmodule

// File: tb/burst_addr_ctr_test.sv
`timescale 1ns/1ps
module burst_addr_ctr_test;
  localparam int AW = 6;
  localparam int BW = 2;
  localparam int UW = AW - BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic          advance = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [BW-1:0] burst_lo;
  logic [AW-1:0] burst_addr;

  int vectors = 0;
  int errors = 0;

  logic [BW-1:0] m_start = '0;
  logic [BW-1:0] m_n = '0;
  logic [UW-1:0] m_upper = '0;
  logic          m_mode = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW), .BEAT_W(BW)) uut (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .order_sel(order_sel), .addr_in(addr_in),
    .burst_lo(burst_lo), .burst_addr(burst_addr));

  function automatic logic [BW-1:0] exp_lo();
    logic [BW-1:0] r;
    if (m_mode) r = m_start ^ m_n;
    else        r = m_start + m_n;
    return r;
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    ea = {m_upper, exp_lo()};
    vectors++;
    if (burst_lo !== exp_lo() || burst_addr !== ea) begin
      errors++;
      $display("FAIL %s: burst_lo=%0d burst_addr=%0h expected lo=%0d addr=%0h",
               tag, burst_lo, burst_addr, exp_lo(), ea);
    end
  endtask

  task automatic cyc(input logic ld, input logic adv, input logic md,
                     input logic [AW-1:0] a, input string tag);
    load = ld; advance = adv; order_sel = md; addr_in = a;
    @(posedge clk);
    m_mode = md;
    if (ld) begin
      m_start = a[BW-1:0];
      m_upper = a[AW-1:BW];
      m_n = '0;
    end else if (adv) begin
      m_n = m_n + 1'b1;
    end
    #1;
    check(tag);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset with noisy inputs
    load = 1'b1; advance = 1'b1; addr_in = '1; order_sel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rst = 1'b0;
    load = 1'b0; advance = 1'b0; order_sel = 1'b0; addr_in = '0;
    m_mode = 1'b0;

    for (int md = 0; md < 2; md++) begin
      for (int u = 0; u < (1 << UW); u++) begin
        for (int s = 0; s < (1 << BW); s++) begin
          cyc(1'b1, 1'b0, md[0], {u[UW-1:0], s[BW-1:0]}, "R2 load");
          for (int k = 0; k < 6; k++) begin
            logic [AW-1:0] noise;
            noise = AW'(k * 13 + u * 7 + s);
            if (k >= 4)  cyc(1'b0, 1'b1, md[0], noise, "R6 wrap");
            else if (md) cyc(1'b0, 1'b1, md[0], noise, "R5 interleaved");
            else         cyc(1'b0, 1'b1, md[0], noise, "R4 linear");
            cyc(1'b0, 1'b0, md[0], ~noise, "R3 hold / R8 upper held");
          end
          cyc(1'b1, 1'b1, md[0], {~u[UW-1:0], ~s[BW-1:0]}, "R7 load over advance");
          cyc(1'b0, 1'b1, md[0], '0, md ? "R5 after R7" : "R4 after R7");
        end
      end
    end

    // R1: reset in the middle of a burst
    cyc(1'b1, 1'b0, 1'b0, 6'h2B, "R2 load before reset");
    rst = 1'b1;
    @(posedge clk);
    m_start = '0; m_n = '0; m_upper = '0;
    #1;
    check("R1 mid-burst reset");
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule